// File: doc/BRIEF.md
# Directory Sharing-Pattern Classifier

This block runs beside a coherence directory and watches the permission requests that the directory grants. Each request names a directory line, the requesting core and whether it asks for write or read permission. For every line the block keeps one bit per core for each role. A write-permission request marks the requester as a producer of the line. A read-permission request marks it as a consumer. Because a core is recorded only once per role, a core that asks again adds nothing. From the number of distinct producers and consumers the block derives a sharing class for the line. It also derives a signed consumer-minus-producer balance that fits the 6-bit per-entry budget of a 32-core directory.

Software or a run-time monitor picks a line with `query_line` and reads back that line's class, producer count, consumer count and balance. The read is combinational and reflects every event accepted up to the last clock edge. The block also keeps, for each class, a count of the lines currently in that class, selected through `tally_sel`. A directory eviction wipes the record of one line. A phase-clear input wipes every record and every tally at once, so that detection can restart at a program phase boundary.

Top module: `sharing_classifier`

## Requirements
- R1: A request with `req_write`=1 sets the requesting core in the line's producer set, and `req_write`=0 sets it in the consumer set. `q_producers` and `q_consumers` report how many distinct cores are in each set, so a repeated request from the same core in the same role leaves the count unchanged.
- R2: A line with exactly one producer and exactly one consumer reports class 1 (private). This rule is checked before all others.
- R3: A line with at least one consumer and no producer reports class 2 (read-only).
- R4: A line outside the rules of R2 and R3 that has more consumers than producers reports class 3 (producer/consumer).
- R5: A line outside the rules of R2, R3 and R4 that has at least one producer reports class 4 (migratory).
- R6: A line with no recorded producer and no recorded consumer reports class 0 (unclassified).
- R7: `q_balance` is the two's-complement value of consumers minus producers, held in 6 bits. It saturates at +31, and its lowest value is -32.
- R8: An eviction clears the record of `evict_line`, so the line reads class 0 with zero counts. A request to the same line in the same cycle is dropped, while a request to a different line in that cycle is still recorded.
- R9: While `phase_clr` is high at a clock edge, every line record and every tally is cleared, and any request or eviction in that cycle is ignored.
- R10: `tally_count` gives the number of lines whose class currently equals `tally_sel` for codes 1 to 4, and reads 0 for codes 0, 5, 6 and 7. A tally changes only when a line moves between classes.
- R11: After reset every line is class 0 with zero counts and zero balance, and every tally is 0.
- R12: The query outputs change in the first cycle after the clock edge that accepts an event. They do not change earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_clr | input | 1 | Clears all records and tallies at the next edge |
| req_valid | input | 1 | A granted permission request is present |
| req_line | input | 4 | Directory line of the request |
| req_core | input | 5 | Requesting core |
| req_write | input | 1 | 1 = write permission (production), 0 = read permission (consumption) |
| evict_valid | input | 1 | A directory entry is evicted |
| evict_line | input | 4 | Line being evicted |
| query_line | input | 4 | Line whose record is reported |
| q_class | output | 3 | Class of the queried line: 0 unclassified, 1 private, 2 read-only, 3 producer/consumer, 4 migratory |
| q_producers | output | 6 | Distinct producers of the queried line |
| q_consumers | output | 6 | Distinct consumers of the queried line |
| q_balance | output | 6 | Saturated signed consumers minus producers |
| tally_sel | input | 3 | Class code whose line count is read |
| tally_count | output | 5 | Lines currently in the selected class |

## Verification
The assertions assume that line and core indices stay inside the configured table, which holds for the default powers of two. They also assume that the query line stays fixed across a cycle whenever a clearing event is checked for its effect on the query. The properties that link class and balance hold only if the class rules and the saturation agree for every count pair that distinct-core tracking can produce. The stimulus therefore covers the extremes: all 32 cores reading one line, all 32 cores writing one line, and cores repeating themselves. It also drives the collisions between eviction, request and phase clear, both directed and at random.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_PRIV = 3'd1,
    CLS_RO   = 3'd2,
    CLS_PC   = 3'd3,
    CLS_MIG  = 3'd4
  } sc_class_e;

  localparam int NUM_CLASSES = 4;

  // Rule order: private, read-only, producer/consumer, migratory.
  function automatic sc_class_e sc_classify(input int unsigned prod_n,
                                            input int unsigned cons_n);
    sc_class_e c;
    if (prod_n == 1 && cons_n == 1)      c = CLS_PRIV;
    else if (cons_n >= 1 && prod_n == 0) c = CLS_RO;
    else if (cons_n > prod_n)            c = CLS_PC;
    else if (prod_n >= 1)                c = CLS_MIG;
    else                                 c = CLS_NONE;
    return c;
  endfunction

  function automatic int sc_sat_balance(input int cons_n, input int prod_n,
                                        input int hi, input int lo);
    int d;
    d = cons_n - prod_n;
    if (d > hi) d = hi;
    if (d < lo) d = lo;
    return d;
  endfunction

endpackage

// File: rtl/sc_line_track.sv
module sc_line_track #(
  parameter int NUM_CORES = 32,
  parameter int CORE_W    = $clog2(NUM_CORES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  hit,
  input  logic [CORE_W-1:0]     core,
  input  logic                  is_write,
  input  logic                  drop,
  output logic [NUM_CORES-1:0]  prod_mask,
  output logic [NUM_CORES-1:0]  cons_mask,
  output sc_pkg::sc_class_e     cls_now,
  output sc_pkg::sc_class_e     cls_next
);
  import sc_pkg::*;

  logic [NUM_CORES-1:0] prod_d, cons_d;

  always_comb begin
    prod_d = prod_mask;
    cons_d = cons_mask;
    if (clr || drop) begin
      prod_d = '0;
      cons_d = '0;
    end else if (hit) begin
      if (is_write) prod_d[core] = 1'b1;
      else          cons_d[core] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_mask <= '0;
      cons_mask <= '0;
    end else begin
      prod_mask <= prod_d;
      cons_mask <= cons_d;
    end
  end

  assign cls_now  = sc_classify($countones(prod_mask), $countones(cons_mask));
  assign cls_next = sc_classify($countones(prod_d), $countones(cons_d));

endmodule

// File: rtl/sc_tally.sv
module sc_tally #(
  parameter int NUM_LINES = 16,
  parameter int TALLY_W   = $clog2(NUM_LINES + 1)
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      clr,
  input  logic                                      a_valid,
  input  sc_pkg::sc_class_e                         a_old,
  input  sc_pkg::sc_class_e                         a_new,
  input  logic                                      b_valid,
  input  sc_pkg::sc_class_e                         b_old,
  input  sc_pkg::sc_class_e                         b_new,
  output logic [sc_pkg::NUM_CLASSES:1][TALLY_W-1:0] counts
);
  import sc_pkg::*;

  logic a_move, b_move;
  assign a_move = a_valid && (a_old != a_new);
  assign b_move = b_valid && (b_old != b_new);

  for (genvar k = 1; k <= NUM_CLASSES; k++) begin : g_cls
    logic up_a, up_b, dn_a, dn_b;
    assign up_a = a_move && (a_new == sc_class_e'(k));
    assign up_b = b_move && (b_new == sc_class_e'(k));
    assign dn_a = a_move && (a_old == sc_class_e'(k));
    assign dn_b = b_move && (b_old == sc_class_e'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   counts[k] <= '0;
      else if (clr) counts[k] <= '0;
      else          counts[k] <= TALLY_W'(int'(counts[k]) + int'(up_a) + int'(up_b)
                                          - int'(dn_a) - int'(dn_b));
    end
  end

endmodule

// File: rtl/sharing_classifier.sv
module sharing_classifier #(
  parameter int NUM_LINES = 16,
  parameter int NUM_CORES = 32,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int CORE_W    = $clog2(NUM_CORES),
  parameter int CNT_W     = $clog2(NUM_CORES + 1),
  parameter int BAL_W     = $clog2(NUM_CORES) + 1,
  parameter int TALLY_W   = $clog2(NUM_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_clr,
  input  logic               req_valid,
  input  logic [LINE_W-1:0]  req_line,
  input  logic [CORE_W-1:0]  req_core,
  input  logic               req_write,
  input  logic               evict_valid,
  input  logic [LINE_W-1:0]  evict_line,
  input  logic [LINE_W-1:0]  query_line,
  output logic [2:0]         q_class,
  output logic [CNT_W-1:0]   q_producers,
  output logic [CNT_W-1:0]   q_consumers,
  output logic [BAL_W-1:0]   q_balance,
  input  logic [2:0]         tally_sel,
  output logic [TALLY_W-1:0] tally_count
);
  import sc_pkg::*;

  localparam int BAL_HI = (1 << (BAL_W - 1)) - 1;
  localparam int BAL_LO = -(1 << (BAL_W - 1));

  logic [NUM_CORES-1:0] prod_arr [NUM_LINES];
  logic [NUM_CORES-1:0] cons_arr [NUM_LINES];
  sc_class_e            now_arr  [NUM_LINES];
  sc_class_e            next_arr [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit_i, drop_i;
    assign hit_i  = req_valid   && (req_line   == LINE_W'(i));
    assign drop_i = evict_valid && (evict_line == LINE_W'(i));

    sc_line_track #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (phase_clr),
      .hit       (hit_i),
      .core      (req_core),
      .is_write  (req_write),
      .drop      (drop_i),
      .prod_mask (prod_arr[i]),
      .cons_mask (cons_arr[i]),
      .cls_now   (now_arr[i]),
      .cls_next  (next_arr[i])
    );
  end

  // Named class-change events for the tallies and the checker.
  logic      ev_req_ok, ev_evict_ok;
  sc_class_e ev_req_old, ev_req_new, ev_evict_old;
  assign ev_req_ok    = req_valid && !phase_clr && !(evict_valid && evict_line == req_line);
  assign ev_evict_ok  = evict_valid && !phase_clr;
  assign ev_req_old   = now_arr[req_line];
  assign ev_req_new   = next_arr[req_line];
  assign ev_evict_old = now_arr[evict_line];

  logic [NUM_CLASSES:1][TALLY_W-1:0] counts;

  sc_tally #(.NUM_LINES(NUM_LINES), .TALLY_W(TALLY_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (phase_clr),
    .a_valid (ev_req_ok),
    .a_old   (ev_req_old),
    .a_new   (ev_req_new),
    .b_valid (ev_evict_ok),
    .b_old   (ev_evict_old),
    .b_new   (CLS_NONE),
    .counts  (counts)
  );

  // Query path
  int q_prod_i, q_cons_i;
  assign q_prod_i    = $countones(prod_arr[query_line]);
  assign q_cons_i    = $countones(cons_arr[query_line]);
  assign q_class     = now_arr[query_line];
  assign q_producers = CNT_W'(q_prod_i);
  assign q_consumers = CNT_W'(q_cons_i);
  assign q_balance   = BAL_W'(sc_sat_balance(q_cons_i, q_prod_i, BAL_HI, BAL_LO));

  always_comb begin
    tally_count = '0;
    if (tally_sel >= 3'd1 && tally_sel <= 3'(NUM_CLASSES))
      tally_count = counts[tally_sel];
  end

  // Sum of tallies, brought out for the checker.
  logic [TALLY_W+1:0] tally_total;
  always_comb begin
    tally_total = '0;
    for (int k = 1; k <= NUM_CLASSES; k++)
      tally_total = tally_total + (TALLY_W+2)'(counts[k]);
  end

endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = 4,
  parameter int BAL_W     = 6,
  parameter int TALLY_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               phase_clr,
  input logic               evict_valid,
  input logic [LINE_W-1:0]  evict_line,
  input logic [LINE_W-1:0]  query_line,
  input logic [2:0]         q_class,
  input logic [BAL_W-1:0]   q_balance,
  input logic [TALLY_W+1:0] tally_total
);

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> (tally_total == '0)); // R9

  AST_CLR_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> (q_class == 3'd0)); // R9

  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tally_total <= (TALLY_W+2)'(NUM_LINES)); // R10

  AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !phase_clr && evict_line == query_line)
      |=> (!$stable(query_line) || q_class == 3'd0)); // R8

  AST_NONE_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_class == 3'd0) |-> (q_balance == '0)); // R6

  AST_PRIV_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_class == 3'd1) |-> (q_balance == '0)); // R2

  AST_RO_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_class == 3'd2) |-> ($signed(q_balance) > 0)); // R3

  AST_PC_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_class == 3'd3) |-> ($signed(q_balance) > 0)); // R4

  AST_MIG_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_class == 3'd4) |-> ($signed(q_balance) <= 0)); // R5

  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    q_class <= 3'd4); // R6

endmodule

bind sharing_classifier sc_checker #(
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W),
  .BAL_W     (BAL_W),
  .TALLY_W   (TALLY_W)
) u_sc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase_clr   (phase_clr),
  .evict_valid (evict_valid),
  .evict_line  (evict_line),
  .query_line  (query_line),
  .q_class     (q_class),
  .q_balance   (q_balance),
  .tally_total (tally_total)
);

// File: tb/test_sharing_classifier.sv
`timescale 1ns/1ps
module test_sharing_classifier;

  localparam int NL = 16;
  localparam int NC = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_clr = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_line = '0;
  logic [4:0] req_core = '0;
  logic       req_write = 1'b0;
  logic       evict_valid = 1'b0;
  logic [3:0] evict_line = '0;
  logic [3:0] query_line = '0;
  logic [2:0] q_class;
  logic [5:0] q_producers, q_consumers, q_balance;
  logic [2:0] tally_sel = '0;
  logic [4:0] tally_count;

  always #4 clk = ~clk;

  sharing_classifier i_sharing_classifier (
    .clk(clk), .rst_n(rst_n), .phase_clr(phase_clr),
    .req_valid(req_valid), .req_line(req_line), .req_core(req_core),
    .req_write(req_write), .evict_valid(evict_valid), .evict_line(evict_line),
    .query_line(query_line), .q_class(q_class), .q_producers(q_producers),
    .q_consumers(q_consumers), .q_balance(q_balance),
    .tally_sel(tally_sel), .tally_count(tally_count)
  );

  int checks = 0;
  int bad = 0;
  int sel_rot = 0;
  bit done = 0;

  // Reference state: sets of cores per line, kept as queues.
  int wr_set[NL][$];
  int rd_set[NL][$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit in_set(input int q[$], input int v);
    foreach (q[k]) if (q[k] == v) return 1;
    return 0;
  endfunction

  function automatic int ref_class(input int p, input int c);
    if (p == 0 && c == 0) return 0;
    if (p == 1 && c == 1) return 1;
    if (p == 0) return 2;
    if (c > p) return 3;
    return 4;
  endfunction

  function automatic string class_tag(input int cl);
    case (cl)
      0: return "R6 class";
      1: return "R2 class";
      2: return "R3 class";
      3: return "R4 class";
      default: return "R5 class";
    endcase
  endfunction

  function automatic int ref_tally(input int sel);
    int n = 0;
    if (sel < 1 || sel > 4) return 0;
    for (int l = 0; l < NL; l++)
      if (ref_class(wr_set[l].size(), rd_set[l].size()) == sel) n++;
    return n;
  endfunction

  task automatic compare_all();
    int l, p, c, b;
    l = query_line;
    p = wr_set[l].size();
    c = rd_set[l].size();
    b = c - p;
    if (b > 31) b = 31;
    chk(class_tag(ref_class(p, c)), q_class, ref_class(p, c));
    chk("R1 producers", q_producers, p);
    chk("R1 consumers", q_consumers, c);
    chk("R7 balance", $signed(q_balance), b);
    chk("R10 tally", tally_count, ref_tally(tally_sel));
  endtask

  // One clock: drive, advance, update the reference, compare.
  task automatic cyc(input bit rv, input int rl, input int rc, input bit rw,
                     input bit ev, input int el, input bit clr, input int ql);
    req_valid = rv; req_line = 4'(rl); req_core = 5'(rc); req_write = rw;
    evict_valid = ev; evict_line = 4'(el); phase_clr = clr;
    query_line = 4'(ql); tally_sel = 3'(sel_rot % 8); sel_rot++;
    @(posedge clk);
    if (clr) begin
      for (int l = 0; l < NL; l++) begin wr_set[l].delete(); rd_set[l].delete(); end
    end else begin
      if (ev) begin wr_set[el].delete(); rd_set[el].delete(); end
      if (rv && !(ev && el == rl)) begin
        if (rw) begin if (!in_set(wr_set[rl], rc)) wr_set[rl].push_back(rc); end
        else    begin if (!in_set(rd_set[rl], rc)) rd_set[rl].push_back(rc); end
      end
    end
    #1;
    req_valid = 0; evict_valid = 0; phase_clr = 0;
    compare_all();
  endtask

  task automatic req(input int l, input int c, input bit w);
    cyc(1, l, c, w, 0, 0, 0, l);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    if (!done) begin
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R11: reset state
    for (int s = 0; s < 8; s++) begin
      tally_sel = 3'(s); #1;
      chk("R11 tally after reset", tally_count, 0);
    end
    query_line = 4'd9; #1;
    chk("R11 class after reset", q_class, 0);
    chk("R11 balance after reset", q_balance, 0);

    // R12: result only after the edge
    req_valid = 1; req_line = 4'd1; req_core = 5'd3; req_write = 1; query_line = 4'd1;
    #1;
    chk("R12 before edge", q_class, 0);
    req(1, 3, 1);
    chk("R12 after edge", q_class, 4);
    req(1, 3, 0);
    chk("R2 private", q_class, 1);
    req(1, 3, 0);
    chk("R1 repeat consumer", q_consumers, 1);

    // R3 then R4
    for (int c = 0; c < 5; c++) req(2, c, 0);
    chk("R3 read-only", q_class, 2);
    chk("R7 balance ro", $signed(q_balance), 5);
    req(2, 9, 1);
    chk("R4 producer/consumer", q_class, 3);

    // R5
    req(3, 1, 1); req(3, 2, 1); req(3, 5, 0);
    chk("R5 migratory", q_class, 4);
    req(4, 7, 1);
    chk("R5 writer only", q_class, 4);

    // R7 saturation
    for (int c = 0; c < NC; c++) req(5, c, 0);
    chk("R7 saturate high", $signed(q_balance), 31);
    for (int c = 0; c < NC; c++) req(6, c, 1);
    chk("R7 lowest", $signed(q_balance), -32);

    // R8: eviction beats same-line request
    cyc(1, 2, 11, 0, 1, 2, 0, 2);
    chk("R8 evict wins", q_class, 0);
    cyc(1, 7, 4, 0, 1, 3, 0, 7);
    chk("R8 other line kept", q_consumers, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 3);
    chk("R8 evicted line", q_class, 0);

    // R9: phase clear ignores a request
    cyc(1, 8, 2, 1, 1, 5, 1, 8);
    chk("R9 request ignored", q_producers, 0);
    tally_sel = 3'd4; #1;
    chk("R9 tally cleared", tally_count, 0);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      int core = (r < 80) ? $urandom_range(0, 5) : $urandom_range(0, NC - 1);
      cyc($urandom_range(0, 9) < 8, $urandom_range(0, NL - 1), core,
          $urandom_range(0, 1) == 1, r < 8, $urandom_range(0, NL - 1),
          r == 99, $urandom_range(0, NL - 1));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule